// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker

The block sits between the frame buffer fetch path and the display pipeline. It accepts 32-bit memory words over a valid/ready handshake and hands out one pixel per accepted output handshake. A 16-bit mode word sets three things on its own encoded fields: the depth of a stored pixel, how the pixel bits are read, and the width of the colour lanes. Pixels come out either as an 8-bit palette index, with a flag that marks the palette path, or as a 24-bit direct colour value.

Words are kept in a small bit accumulator. Pixels are taken from its least significant end, so 24-bit pixels can span two words without stalling the stream. The block also works out the line length in words that the fetch engine needs. It takes this from the programmed active width and the selected depth.

Top module: `pix_unpack`

## Requirements
- R1: After reset, and while rst_ni is low, pix_valid_o is low and word_ready_o is high.
- R2: Depth field mode_i[2:0] selects bits per pixel: code 2 is 8, code 4 is 16, code 6 is 24, code 7 is 32. Pixels are taken from the lowest unused bits first, so bits [7:0] of the first word give the first 8 bpp pixel.
- R3: Colour field mode_i[12:10] set to any code other than 4 or 5 selects the palette path. pix_index_o is then high, pix_o[7:0] carries the low 8 bits of the pixel and pix_o[23:8] is zero.
- R4: Colour code 5 treats the pixel as 16-bit direct colour: red [15:11], green [10:5], blue [4:0]. Each channel is widened to 8 bits by repeating its top bits below it, and the output is packed as red [23:16], green [15:8], blue [7:0].
- R5: At 24 bpp, every three words yield four pixels. A pixel may take its low bits from one word and its high bits from the next.
- R6: Colour code 4 treats pixel bits [23:16], [15:8] and [7:0] as red, green and blue. At 32 bpp, bits [31:24] have no effect on the output.
- R7: When mode_i[3] is 1 (18-bit lane mode), the two least significant bits of every direct colour channel are forced to zero. When it is 0, all 24 bits pass through.
- R8: line_words_o equals width_i times bits per pixel divided by 32, minus one.
- R9: While pix_valid_o is high and pix_ready_i is low, the pixel holds. No pixel is lost or repeated under any pattern of stalls on either side.
- R10: A depth code other than 2, 4, 6 or 7 behaves as 32 bpp.
- R11: The input accepts a word whenever at most two words' worth of bits are buffered, so a steady 24 bpp stream with both sides ready gives one pixel every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 16 | Mode word: depth [2:0], lane width [3], colour [12:10] |
| width_i | input | 11 | Active line width in pixels |
| line_words_o | output | 11 | Words per line, minus one |
| word_i | input | 32 | Fetched frame buffer word |
| word_valid_i | input | 1 | Word present |
| word_ready_o | output | 1 | Word accepted when high with valid |
| pix_o | output | 24 | Pixel: RGB or index in [7:0] |
| pix_index_o | output | 1 | Pixel is a palette index |
| pix_valid_o | output | 1 | Pixel present |
| pix_ready_i | input | 1 | Downstream takes the pixel |

## Verification
The bench targets four risks. The first is 24 bpp pixels that cross a word boundary: an accumulator that dropped or doubled the leftover byte would shift every later colour channel. The second is the byte order within a word: a design unpacking from the top would reverse each group of four 8 bpp indices. The third is channel widening in the 16-bit colour format, where replicating the wrong bits shows up as off-by-a-few greens and reds. The fourth is random stalls on both handshakes, where a hold or pop error would repeat or skip pixels. Line length arithmetic is checked at each depth, and an unknown depth code is checked against 32 bpp behaviour.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 16;

  localparam logic [2:0] DEPTH_8  = 3'd2;
  localparam logic [2:0] DEPTH_16 = 3'd4;
  localparam logic [2:0] DEPTH_24 = 3'd6;
  localparam logic [2:0] DEPTH_32 = 3'd7;

  localparam logic [2:0] COL_CODE_888 = 3'd4;
  localparam logic [2:0] COL_CODE_565 = 3'd5;

  typedef enum logic [1:0] {
    COL_INDEX,
    COL_888,
    COL_565
  } col_e;

  typedef struct packed {
    logic [5:0] bpp;
    col_e       col;
    logic       lane18;
  } mode_t;
endpackage

// File: rtl/pix_unpack_dec.sv
module pix_unpack_dec
  import pix_unpack_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LINE_W-1:0] width_i,
  output mode_t             mode_o,
  output logic [LINE_W-1:0] line_words_o
);
  localparam int PROD_W = LINE_W + 6;

  logic [PROD_W-1:0] bits_per_line;

  always_comb begin
    unique case (mode_i[2:0])
      DEPTH_8:  mode_o.bpp = 6'd8;
      DEPTH_16: mode_o.bpp = 6'd16;
      DEPTH_24: mode_o.bpp = 6'd24;
      default:  mode_o.bpp = 6'd32;
    endcase
    unique case (mode_i[12:10])
      COL_CODE_888: mode_o.col = COL_888;
      COL_CODE_565: mode_o.col = COL_565;
      default:      mode_o.col = COL_INDEX;
    endcase
    mode_o.lane18 = mode_i[3];
  end

  assign bits_per_line = PROD_W'(width_i) * PROD_W'(mode_o.bpp);
  assign line_words_o  = LINE_W'((bits_per_line >> 5) - PROD_W'(1));
endmodule

// File: rtl/pix_unpack_gear.sv
module pix_unpack_gear
  import pix_unpack_pkg::*;
#(
  parameter int BUF_WORDS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        bpp_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [WORD_W-1:0] raw_o,
  output logic              raw_valid_o,
  input  logic              raw_ready_i
);
  localparam int BUF_W = BUF_WORDS * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int ROOM  = BUF_W - WORD_W;

  logic [BUF_W-1:0] bits_q, bits_d, kept;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_kept;
  logic [CNT_W-1:0] bpp_ext;
  logic [2*WORD_W-1:0] mask;
  logic push, pop;

  assign bpp_ext      = CNT_W'(bpp_i);
  assign raw_valid_o  = cnt_q >= bpp_ext;
  assign word_ready_o = cnt_q <= CNT_W'(ROOM);
  assign push         = word_valid_i && word_ready_o;
  assign pop          = raw_valid_o && raw_ready_i;

  assign mask  = ({{WORD_W{1'b0}}, {WORD_W{1'b1}}} >> (6'd32 - bpp_i));
  assign raw_o = bits_q[WORD_W-1:0] & mask[WORD_W-1:0];

  always_comb begin
    kept     = pop ? (bits_q >> bpp_i) : bits_q;
    cnt_kept = pop ? (cnt_q - bpp_ext) : cnt_q;
    bits_d   = kept;
    cnt_d    = cnt_kept;
    if (push) begin
      bits_d = kept | (BUF_W'(word_i) << cnt_kept);
      cnt_d  = cnt_kept + CNT_W'(WORD_W);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pix_unpack_color.sv
module pix_unpack_color
  import pix_unpack_pkg::*;
(
  input  mode_t             mode_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic [23:0]       pix_o,
  output logic              index_o
);
  logic [7:0] r, g, b;
  logic [7:0] lane_mask;

  assign lane_mask = mode_i.lane18 ? 8'hfc : 8'hff;

  always_comb begin
    r = raw_i[23:16];
    g = raw_i[15:8];
    b = raw_i[7:0];
    if (mode_i.col == COL_565) begin
      r = {raw_i[15:11], raw_i[15:13]};
      g = {raw_i[10:5],  raw_i[10:9]};
      b = {raw_i[4:0],   raw_i[4:2]};
    end
    index_o = (mode_i.col == COL_INDEX);
    if (index_o) pix_o = {16'h0, raw_i[7:0]};
    else         pix_o = {r & lane_mask, g & lane_mask, b & lane_mask};
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int BUF_WORDS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LINE_W-1:0] width_i,
  output logic [LINE_W-1:0] line_words_o,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [23:0]       pix_o,
  output logic              pix_index_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i
);
  mode_t             mode;
  logic [WORD_W-1:0] raw;

  pix_unpack_dec #(.LINE_W(LINE_W)) u_dec (
    .mode_i       (mode_i),
    .width_i      (width_i),
    .mode_o       (mode),
    .line_words_o (line_words_o)
  );

  pix_unpack_gear #(.BUF_WORDS(BUF_WORDS)) u_gear (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bpp_i        (mode.bpp),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .raw_o        (raw),
    .raw_valid_o  (pix_valid_o),
    .raw_ready_i  (pix_ready_i)
  );

  pix_unpack_color u_color (
    .mode_i  (mode),
    .raw_i   (raw),
    .pix_o   (pix_o),
    .index_o (pix_index_o)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
  import pix_unpack_pkg::*;
#(
  parameter int LINE_W    = 11,
  parameter int BUF_WORDS = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic [LINE_W-1:0] width_i,
  input logic [LINE_W-1:0] line_words_o,
  input logic [WORD_W-1:0] word_i,
  input logic              word_valid_i,
  input logic              word_ready_o,
  input logic [23:0]       pix_o,
  input logic              pix_index_o,
  input logic              pix_valid_o,
  input logic              pix_ready_i
);
  assert_idle_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !pix_valid_o && word_ready_o);

  assert_index_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_index_o |-> pix_o[23:8] == 16'h0);

  assert_lane18_low_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_index_o && mode_i[3] |-> (pix_o & 24'h030303) == 24'h0);

  assert_hold_on_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i && $stable(mode_i) |=> pix_valid_o && $stable(pix_o));

  assert_no_deadlock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> word_ready_o);
endmodule

bind pix_unpack pix_unpack_chk #(.LINE_W(LINE_W), .BUF_WORDS(BUF_WORDS)) u_chk (.*);

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;
  localparam int LINE_W = 11;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       mode_i = '0;
  logic [LINE_W-1:0] width_i = '0;
  logic [LINE_W-1:0] line_words_o;
  logic [31:0]       word_i = '0;
  logic              word_valid_i = 1'b0;
  logic              word_ready_o;
  logic [23:0]       pix_o;
  logic              pix_index_o;
  logic              pix_valid_o;
  logic              pix_ready_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  bit q[$];
  bit w_fire, p_fire;
  logic [31:0] w_data;

  always #2.5 clk_i = ~clk_i;

  pix_unpack u_pix_unpack (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int bpp_of(logic [15:0] m);
    case (m[2:0])
      3'd2: return 8;
      3'd4: return 16;
      3'd6: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [24:0] expect_pix(logic [31:0] p, logic [15:0] m);
    logic [7:0] r, g, b, k;
    k = m[3] ? 8'hfc : 8'hff;
    if (m[12:10] == 3'd5) begin
      r = {p[15:11], p[15:13]};
      g = {p[10:5], p[10:9]};
      b = {p[4:0], p[4:2]};
      return {1'b0, r & k, g & k, b & k};
    end else if (m[12:10] == 3'd4) begin
      return {1'b0, p[23:16] & k, p[15:8] & k, p[7:0] & k};
    end
    return {1'b1, 16'h0, p[7:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    word_valid_i = 1'b0;
    pix_ready_i = 1'b0;
    q.delete();
    w_fire = 0;
    p_fire = 0;
    repeat (2) @(negedge clk_i);
    check("R1", {30'h0, pix_valid_o, word_ready_o}, 32'h1, "in reset valid/ready");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {30'h0, pix_valid_o, word_ready_o}, 32'h1, "after reset valid/ready");
  endtask

  // Each negedge: apply the last edge's handshakes to the model, compare, drive.
  task automatic run_phase(string tag, logic [15:0] m, int nwords, int word_pct, int ready_pct);
    int sent = 0;
    int bpp = bpp_of(m);
    int idle = 0;
    mode_i = m;
    do_reset();
    while (idle < 4) begin
      logic [31:0] p;
      logic [24:0] e;
      bit ev, er;
      if (p_fire) for (int i = 0; i < bpp; i++) void'(q.pop_front());
      if (w_fire) for (int i = 0; i < 32; i++) q.push_back(w_data[i]);
      ev = q.size() >= bpp;
      er = q.size() <= 64;
      check(tag, {31'h0, pix_valid_o}, {31'h0, ev}, "pix_valid_o");
      check("R11", {31'h0, word_ready_o}, {31'h0, er}, "word_ready_o");
      if (ev) begin
        p = '0;
        for (int i = 0; i < bpp; i++) p[i] = q[i];
        e = expect_pix(p, m);
        check(tag, {7'h0, pix_index_o, pix_o}, {7'h0, e}, "pixel");
      end
      word_valid_i = (sent < nwords) && ($urandom_range(99) < word_pct);
      word_i = $urandom;
      pix_ready_i = $urandom_range(99) < ready_pct;
      w_fire = word_valid_i && er;
      p_fire = ev && pix_ready_i;
      w_data = word_i;
      if (w_fire) sent++;
      if (sent >= nwords && !ev && !w_fire) idle++;
      @(negedge clk_i);
    end
    check(tag, q.size(), 0, "leftover bits");
  endtask

  task automatic check_line(logic [15:0] m, int w, int exp);
    mode_i = m;
    width_i = LINE_W'(w);
    #1;
    check("R8", {21'h0, line_words_o}, exp, "line_words_o");
  endtask

  initial begin
    run_phase("R2", 16'h0002, 20, 100, 100);
    run_phase("R3", 16'h0004, 16, 100, 100);
    run_phase("R3", 16'h1C02, 12, 100, 100);
    run_phase("R4", 16'h1404, 20, 100, 100);
    run_phase("R5", 16'h1006, 30, 100, 100);
    run_phase("R6", 16'h1007, 20, 100, 100);
    run_phase("R7", 16'h140C, 16, 100, 100);
    run_phase("R7", 16'h100F, 16, 100, 100);
    run_phase("R9", 16'h1006, 60, 60, 50);
    run_phase("R9", 16'h0002, 40, 30, 70);
    run_phase("R10", 16'h1005, 20, 100, 100);
    check_line(16'h0002, 640, 159);
    check_line(16'h1404, 640, 319);
    check_line(16'h1006, 320, 239);
    check_line(16'h1007, 64, 63);
    check_line(16'h1404, 1024, 511);
    check_line(16'h1005, 100, 99);
    done = 1;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule